// File: doc/BRIEF.md
# Double-Buffered Piecewise-Linear Gamma Table

This block sits at the end of one pixel pipe and applies a gamma curve to each of the red, green and blue components. The curve is held as a piecewise-linear table. Each table point stores a base value and a slope for every component. There are two complete copies of the table, A and B, and a bypass path. Software loads the copy that is not in use while the other one keeps serving pixels. Once the load is complete, software requests the new mode. The request takes effect only on the next frame-start pulse, so a frame is never shaded with a mix of two curves.

Loading goes through a single data strobe and an internal point index that advances by itself. Each table point takes six words in a fixed order. A three-bit component mask limits which component tables accept writes. A power-force input keeps the table memory off: while it is set, data words are dropped. The block shows the mode that is in effect on a status output. From that status it also derives which copy the next load should target.

Top module: `gamma_pingpong_lut`

## Requirements
- R1: After reset, status is 0 (bypass), out_valid is 0, and load_target is 1 (the next load goes to copy B).
- R2: While status is 0, each output component equals its input component, zero-extended, one cycle after pix_valid.
- R3: Mode codes are 0 = bypass, 1 = copy A, 2 = copy B. A mode written with mode_wr reaches status only at the clock edge where frame_start is high. Until then, status and the pixel results keep the old mode.
- R4: Each data_wr stores one word. The six words of a point go in this order: red base, green base, blue base, red slope, green slope, blue slope. After the sixth word the point index advances by one and wraps from POINTS-1 to 0.
- R5: wr_mask bit 0 enables red, bit 1 green and bit 2 blue. A word for a component whose mask bit is 0 is not stored, but it still advances the word counter.
- R6: idx_wr loads the point index from idx_val and returns the word counter to red. Writing idx_val = 0 restarts the load at the first point.
- R7: While pwr_force is 1, data_wr has no effect: no word is stored and the word counter and index do not move.
- R8: A committed mode code of 3 yields status 0, and pixels pass through as in bypass.
- R9: load_target is 0 (copy A) when status is 2, and 1 (copy B) when status is 0 or 1. ram_sel = 0 loads copy A and ram_sel = 1 loads copy B.
- R10: In table mode, the top IW bits of each input component pick the point and the low FRAC bits form the fraction f. The output is base + ((slope * f) >> FRAC), truncated to DW bits, one cycle after pix_valid.
- R11: Loading the copy that is not active leaves the pixel results of the active copy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Frame boundary pulse; commits the pending mode |
| pwr_force | input | 1 | 1 holds the table memory powered down |
| ram_sel | input | 1 | Copy to load: 0 = A, 1 = B |
| wr_mask | input | 3 | Component write enables (bit0 red, bit1 green, bit2 blue) |
| idx_wr | input | 1 | Load the point index and reset the word counter |
| idx_val | input | IW | New point index |
| data_wr | input | 1 | Data word strobe |
| data_in | input | DW | Data word |
| mode_wr | input | 1 | Write the pending mode |
| mode_val | input | 2 | Mode code |
| status | output | 2 | Mode in effect |
| load_target | output | 1 | Copy the next load should target: 0 = A, 1 = B |
| pix_valid | input | 1 | Pixel input valid |
| pix_r | input | PW | Red input (point index and fraction) |
| pix_g | input | PW | Green input |
| pix_b | input | PW | Blue input |
| out_valid | output | 1 | Result valid |
| out_r | output | DW | Red result |
| out_g | output | DW | Green result |
| out_b | output | DW | Blue result |

## Verification
Pixels are sent in bypass, through copy A and through copy B. The inputs include the corner points: index 0 with fraction 0, and the last index with the largest fraction. These show whether the lookup chooses the right copy and applies the slope and the shift correctly. Loads with a partial mask, with an index rewritten in the middle of a point, and with power forced on show whether each word lands in the right component, field and point. Pixels are also sent during the window between a mode write and the frame pulse, and while the idle copy is being loaded. These show that the mode switch waits for the frame boundary and that the live curve is never disturbed.

// File: rtl/gamma_pingpong_lut.sv
module gamma_pingpong_lut #(
  parameter int DW     = 16,
  parameter int POINTS = 16,
  parameter int FRAC   = 8,
  localparam int IW    = $clog2(POINTS),
  localparam int PW    = IW + FRAC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          pwr_force,
  input  logic          ram_sel,
  input  logic [2:0]    wr_mask,
  input  logic          idx_wr,
  input  logic [IW-1:0] idx_val,
  input  logic          data_wr,
  input  logic [DW-1:0] data_in,
  input  logic          mode_wr,
  input  logic [1:0]    mode_val,
  output logic [1:0]    status,
  output logic          load_target,
  input  logic          pix_valid,
  input  logic [PW-1:0] pix_r,
  input  logic [PW-1:0] pix_g,
  input  logic [PW-1:0] pix_b,
  output logic          out_valid,
  output logic [DW-1:0] out_r,
  output logic [DW-1:0] out_g,
  output logic [DW-1:0] out_b
);

  logic [DW-1:0] base_m  [2][3][POINTS];
  logic [DW-1:0] slope_m [2][3][POINTS];

  logic [2:0]    wc;
  logic [IW-1:0] idx;
  logic [1:0]    pend;
  logic [1:0]    comp;
  logic          is_slope;
  logic          accept;

  assign accept   = data_wr && !pwr_force && !idx_wr;
  assign is_slope = (wc >= 3'd3);
  assign comp     = is_slope ? 2'(wc - 3'd3) : wc[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc  <= '0;
      idx <= '0;
    end else if (idx_wr) begin
      wc  <= '0;
      idx <= idx_val;
    end else if (accept) begin
      if (wc == 3'd5) begin
        wc  <= '0;
        idx <= IW'(idx + 1'b1);
      end else begin
        wc <= wc + 3'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept && wr_mask[comp]) begin
      if (is_slope) slope_m[ram_sel][comp][idx] <= data_in;
      else          base_m[ram_sel][comp][idx]  <= data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= 2'd0;
      status <= 2'd0;
    end else begin
      if (frame_start) status <= (pend == 2'd3) ? 2'd0 : pend;
      if (mode_wr)     pend   <= mode_val;
    end
  end

  assign load_target = (status != 2'd2);

  logic [PW-1:0] pin  [3];
  logic [DW-1:0] res  [3];
  logic [DW-1:0] outq [3];
  logic          rsel;

  assign pin[0] = pix_r;
  assign pin[1] = pix_g;
  assign pin[2] = pix_b;
  assign rsel   = (status == 2'd2);

  for (genvar c = 0; c < 3; c++) begin : g_comp
    logic [IW-1:0]      seg;
    logic [FRAC-1:0]    fr;
    logic [DW+FRAC-1:0] prod;
    assign seg  = pin[c][PW-1:FRAC];
    assign fr   = pin[c][FRAC-1:0];
    assign prod = slope_m[rsel][c][seg] * fr;
    assign res[c] = (status == 2'd0) ? DW'(pin[c])
                  : DW'(base_m[rsel][c][seg] + prod[DW+FRAC-1:FRAC]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         outq[c] <= '0;
      else if (pix_valid) outq[c] <= res[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= pix_valid;
  end

  assign out_r = outq[0];
  assign out_g = outq[1];
  assign out_b = outq[2];

endmodule

// File: rtl/gamma_pingpong_lut_chk.sv
module gamma_pingpong_lut_chk #(
  parameter int DW = 16,
  parameter int PW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic [1:0]    status,
  input logic          pix_valid,
  input logic [PW-1:0] pix_r,
  input logic          out_valid,
  input logic [DW-1:0] out_r
);

  a_r8_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'd3);

  a_r3_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(status));

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);

  a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && status == 2'd0) |=> (out_r == DW'($past(pix_r))));

endmodule

bind gamma_pingpong_lut gamma_pingpong_lut_chk #(.DW(DW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .status(status),
  .pix_valid(pix_valid), .pix_r(pix_r), .out_valid(out_valid), .out_r(out_r)
);

// File: tb/gamma_pingpong_lut_test.sv
module gamma_pingpong_lut_test;
  localparam int DW = 16, POINTS = 16, FRAC = 8, IW = 4, PW = 12;

  logic clk = 0, rst_n = 0;
  logic frame_start = 0, pwr_force = 1, ram_sel = 0;
  logic [2:0] wr_mask = 3'b111;
  logic idx_wr = 0, data_wr = 0, mode_wr = 0, pix_valid = 0;
  logic [IW-1:0] idx_val = '0;
  logic [DW-1:0] data_in = '0;
  logic [1:0] mode_val = '0;
  logic [PW-1:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic [1:0] status;
  logic load_target, out_valid;
  logic [DW-1:0] out_r, out_g, out_b;

  always #5 clk = ~clk;

  gamma_pingpong_lut #(.DW(DW), .POINTS(POINTS), .FRAC(FRAC)) uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pwr_force(pwr_force),
    .ram_sel(ram_sel), .wr_mask(wr_mask), .idx_wr(idx_wr), .idx_val(idx_val),
    .data_wr(data_wr), .data_in(data_in), .mode_wr(mode_wr), .mode_val(mode_val),
    .status(status), .load_target(load_target), .pix_valid(pix_valid),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .out_valid(out_valid),
    .out_r(out_r), .out_g(out_g), .out_b(out_b));

  int total = 0, fails = 0;
  int mb [2][3][POINTS];
  int md [2][3][POINTS];
  int m_wc = 0, m_idx = 0, m_pend = 0, m_status = 0;
  logic [47:0] expq [$];
  string tagq [$];

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expc(int c, int v);
    int seg, fr, rs;
    if (m_status == 0) return v;
    seg = v >> FRAC; fr = v & ((1 << FRAC) - 1); rs = (m_status == 2) ? 1 : 0;
    return (mb[rs][c][seg] + ((md[rs][c][seg] * fr) >> FRAC)) & 16'hFFFF;
  endfunction

  always @(negedge clk) begin
    if (out_valid) begin
      if (expq.size() == 0) chk(0, "R10 unexpected result", 1, 0);
      else begin
        logic [47:0] e;
        string t;
        e = expq.pop_front(); t = tagq.pop_front();
        chk({out_r, out_g, out_b} == e, t, int'({out_r, out_g, out_b} % 48'h7fffffff),
            int'(e % 48'h7fffffff));
      end
    end
  end

  task automatic pix(int r, int g, int b, string tag);
    pix_valid = 1; pix_r = PW'(r); pix_g = PW'(g); pix_b = PW'(b);
    expq.push_back({16'(expc(0, r)), 16'(expc(1, g)), 16'(expc(2, b))});
    tagq.push_back(tag);
    @(negedge clk);
    pix_valid = 0;
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  task automatic set_idx(int v);
    idx_wr = 1; idx_val = IW'(v);
    @(negedge clk);
    idx_wr = 0; m_idx = v; m_wc = 0;
  endtask

  task automatic word(int v);
    data_wr = 1; data_in = DW'(v);
    @(negedge clk);
    data_wr = 0;
    if (!pwr_force) begin
      int c;
      c = m_wc % 3;
      if (wr_mask[c]) begin
        if (m_wc < 3) mb[ram_sel][c][m_idx] = v;
        else          md[ram_sel][c][m_idx] = v;
      end
      m_wc++;
      if (m_wc == 6) begin m_wc = 0; m_idx = (m_idx + 1) % POINTS; end
    end
  endtask

  task automatic load_all(int rs);
    ram_sel = rs[0];
    set_idx(0);
    for (int i = 0; i < POINTS; i++) begin
      for (int c = 0; c < 3; c++) word(rs * 2000 + i * 300 + c * 40 + 7);
      for (int c = 0; c < 3; c++) word(20 + i * 3 + c * 5 + rs * 11);
    end
  endtask

  task automatic set_mode(int v);
    mode_wr = 1; mode_val = 2'(v);
    @(negedge clk);
    mode_wr = 0; m_pend = v;
  endtask

  task automatic frame();
    frame_start = 1;
    @(negedge clk);
    frame_start = 0; m_status = (m_pend == 3) ? 0 : m_pend;
  endtask

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(status == 0, "R1 reset status", status, 0);
    chk(load_target == 1, "R1 reset load_target", load_target, 1);
    chk(out_valid == 0, "R1 reset out_valid", out_valid, 0);

    pix(12'h000, 12'hFFF, 12'h5A3, "R2 bypass corners");
    pix(12'h123, 12'h800, 12'h7FF, "R2 bypass mid");
    drain();

    // R7: words during power-down are dropped, counter stays
    set_idx(0);
    word(16'hBEEF); word(16'hBEEF);
    pwr_force = 0;
    load_all(0);
    set_mode(1);
    repeat (3) @(negedge clk);
    chk(status == 0, "R3 status held before frame", status, 0);
    pix(12'h3A0, 12'h111, 12'h222, "R3 still bypass before frame");
    drain();
    frame();
    chk(status == 1, "R3 status after frame", status, 1);
    chk(load_target == 1, "R9 load_target after A", load_target, 1);
    pix(12'h000, 12'h000, 12'h000, "R10 point 0 frac 0");
    pix(12'hFFF, 12'hFFF, 12'hFFF, "R10 last point max frac (R4 wrap load)");
    pix(12'h380, 12'h5C4, 12'h901, "R10 mid points");
    pix(12'hA7F, 12'h240, 12'hC01, "R4 point order");
    drain();

    // R7 again on live copy
    pwr_force = 1;
    set_idx(3);
    repeat (6) word(16'hDEAD);
    pwr_force = 0;
    pix(12'h380, 12'h3FF, 12'h301, "R7 power-forced writes ignored");
    drain();

    // R11 load B while A live
    load_all(1);
    pix(12'h380, 12'h5C4, 12'h901, "R11 A unchanged during B load");
    pix(12'hFFF, 12'h000, 12'h7AA, "R11 A unchanged corners");
    drain();
    set_mode(2);
    frame();
    chk(status == 2, "R3 status B", status, 2);
    chk(load_target == 0, "R9 load_target after B", load_target, 0);
    pix(12'h380, 12'h5C4, 12'h901, "R9 copy B lookup");
    pix(12'hFFF, 12'h0FF, 12'hE80, "R10 copy B corners");
    drain();

    // R5 partial mask into copy A, then R4 index auto-advance
    ram_sel = 0; wr_mask = 3'b010;
    set_idx(5);
    word(16'h0A00); word(16'h0B00); word(16'h0C00);
    word(16'h0011); word(16'h0022); word(16'h0033);
    wr_mask = 3'b111;
    word(16'h0100); word(16'h0200); word(16'h0300);
    word(16'h0040); word(16'h0050); word(16'h0060);
    // R6 index rewrite mid-point
    set_idx(9);
    word(16'h7777); word(16'h6666);
    set_idx(9);
    word(16'h0900); word(16'h0901); word(16'h0902);
    word(16'h0008); word(16'h0009); word(16'h000A);
    set_mode(1);
    frame();
    pix(12'h580, 12'h580, 12'h580, "R5 mask kept red/blue, wrote green");
    pix(12'h640, 12'h6FF, 12'h600, "R4 index advanced to next point");
    pix(12'h900, 12'h980, 12'h9FF, "R6 index write restarts at red");
    drain();

    // R8 code 3 commits as bypass
    set_mode(3);
    frame();
    chk(status == 0, "R8 code 3 status", status, 0);
    pix(12'h9AB, 12'h001, 12'hFFE, "R8 code 3 passes through");
    drain();

    chk(expq.size() == 0, "R10 all results seen", expq.size(), 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule